// File: doc/BRIEF.md
# Baud Divisor Setting Calculator

This unit works out the two settings of a two-stage baud generator: a power-of-two prescaler exponent `m` and an 8-bit divisor `k`. A configuration engine hands it a reference clock frequency in hertz and a target baud rate, then pulses `start`. The block forms the real quotient `fclk / (2 * baud)`. It halves that quotient and counts up `m` until the value drops below 256. It then rounds the value to the nearest integer. If rounding pushes the value up to 256, it replaces it with 128 and adds one more step to `m`.

The quotient comes from a restoring shift-subtract divider that produces one bit per cycle and carries fractional bits below the binary point. Normalization removes one power of two per cycle. Rounding and the overflow fix-up take a single further cycle. The block then raises a one-cycle `done` strobe. On the same cycle it raises `rangeErr` if the target baud was zero or if the exponent ended above the limit. `mExp`, `kDiv` and `rangeErr` hold their values until the next computation completes.

Top module: `baud_divisor_calc`

## Requirements
- R1: After reset, `done`, `rangeErr`, `mExp` and `kDiv` are all 0.
- R2: For a nonzero target `b`, `mExp` is the smallest m for which `fclkHz / (2*b*2^m)` is below 256. The values 20,000,000 Hz and 153,600 bps give m=0, k=65. The values 20,000,000 Hz and 300 bps give m=8, k=130.
- R3: `kDiv` is `fclkHz / (2*b*2^m)` rounded to the nearest integer, with an exact half rounded up. Equivalently, `kDiv = (floor(2*fclkHz/(2*b*2^m)) + 1) / 2` in integer arithmetic.
- R4: When the rounding of R3 produces 256, `kDiv` is 128 and `mExp` is one greater than the value given by R2.
- R5: `rangeErr` is 1 with `done` when the final exponent, including any R4 increment, is above 8. Otherwise it is 0, and `mExp` and `kDiv` are then the values given by R2 to R4.
- R6: A target baud of 0 gives `rangeErr` = 1 with `done`.
- R7: `done` is high for exactly one cycle per computation. `mExp`, `kDiv` and `rangeErr` do not change in any cycle where `done` is low.
- R8: A `start` pulse that arrives while a computation is in progress is ignored. The running result is not disturbed, and no extra `done` is produced.
- R9: Whenever `done` is high with `rangeErr` low and `mExp` nonzero, `kDiv` lies in 128 to 255, so bit 7 of `kDiv` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only when idle |
| fclkHz | input | 25 | Reference clock frequency in Hz |
| baudTarget | input | 24 | Target baud rate in bit/s |
| mExp | output | 4 | Prescaler exponent m |
| kDiv | output | 8 | Divisor k |
| done | output | 1 | One-cycle result strobe |
| rangeErr | output | 1 | Result not representable (m above 8 or zero baud) |

## Verification
The sweeps place the scaled quotient on both sides of 256. They include exact x.5 cases such as 509 and 511 Hz against 1 bps; a design that truncated would return 254 there, or would miss the 256-to-128 fix-up and emit k=0 or m one too small. Frequencies around 131,000 Hz at 1 bps probe the exponent limit. There, a missing fix-up before the range test would report m=8 with a wrapped k instead of raising the error. Zero baud, restarts during a run and output holding are also exercised: a divide-by-zero design would emit garbage without the flag, and a design that re-armed on a stray start would corrupt the result or strobe twice.

// File: rtl/baud_calc_pkg.sv
package baud_calc_pkg;

  typedef struct packed {
    logic load;
    logic divStep;
    logic shift;
    logic round;
  } calcStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_NORM,
    ST_ROUND,
    ST_DONE
  } calcState_t;

endpackage

// File: rtl/baud_calc_control.sv
module baud_calc_control
  import baud_calc_pkg::*;
#(
  parameter int DIV_STEPS = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         kBig,
  output calcStrobes_t strobes,
  output logic         done
);

  localparam int CNT_W = $clog2(DIV_STEPS + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIV_STEPS - 1);

  calcState_t state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.load = 1'b1;
          stateNext    = ST_DIV;
        end
      end
      ST_DIV: begin
        strobes.divStep = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_NORM;
      end
      ST_NORM: begin
        if (kBig) strobes.shift = 1'b1;
        else      stateNext     = ST_ROUND;
      end
      ST_ROUND: begin
        strobes.round = 1'b1;
        stateNext     = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.load)         stepCnt <= '0;
      else if (strobes.divStep) stepCnt <= stepCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/baud_calc_datapath.sv
module baud_calc_datapath
  import baud_calc_pkg::*;
#(
  parameter int CLK_W  = 25,
  parameter int BAUD_W = 24,
  parameter int FRAC_W = 2,
  parameter int K_W    = 8,
  parameter int M_MAX  = 8,
  localparam int MOW   = $clog2(M_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  calcStrobes_t      strobes,
  input  logic [CLK_W-1:0]  fclkIn,
  input  logic [BAUD_W-1:0] baudIn,
  output logic              kBig,
  output logic [MOW-1:0]    mOut,
  output logic [K_W-1:0]    kOut,
  output logic              errOut
);

  localparam int NUM_W = CLK_W + FRAC_W;
  localparam int DIV_W = BAUD_W + 1;
  localparam int QW    = NUM_W;
  localparam int MW    = $clog2(QW + 2);
  localparam logic [MW-1:0] M_LIMIT = MW'(M_MAX);

  logic [NUM_W-1:0] numSh;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] remR;
  logic [QW-1:0]    quot;
  logic [MW-1:0]    mCnt;
  logic             zeroBaud;
  logic [K_W-1:0]   kR;
  logic [MOW-1:0]   mR;
  logic             errR;

  // one restoring division step
  logic [DIV_W:0]   trial;
  logic [DIV_W:0]   diff;
  logic             fits;
  logic [DIV_W-1:0] remNext;

  always_comb begin
    trial   = {remR, numSh[NUM_W-1]};
    fits    = trial >= {1'b0, divisor};
    diff    = trial - {1'b0, divisor};
    remNext = fits ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
  end

  // normalization test: integer part of quotient reaches 2^K_W
  assign kBig = |quot[QW-1:FRAC_W+K_W];

  // rounding on the first fractional bit, plus overflow fix-up
  logic [K_W+1:0] roundSum;
  logic [K_W:0]   kRounded;
  logic           roundOvf;
  logic [K_W-1:0] kFinal;
  logic [MW-1:0]  mFinal;

  always_comb begin
    roundSum = {1'b0, quot[FRAC_W+K_W-1:FRAC_W-1]} + (K_W+2)'(1);
    kRounded = roundSum[K_W+1:1];
    roundOvf = kRounded[K_W];
    kFinal   = roundOvf ? {1'b1, {(K_W-1){1'b0}}} : kRounded[K_W-1:0];
    mFinal   = mCnt + MW'(roundOvf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      numSh    <= '0;
      divisor  <= '0;
      remR     <= '0;
      quot     <= '0;
      mCnt     <= '0;
      zeroBaud <= 1'b0;
      kR       <= '0;
      mR       <= '0;
      errR     <= 1'b0;
    end else begin
      if (strobes.load) begin
        numSh    <= {fclkIn, {FRAC_W{1'b0}}};
        divisor  <= {baudIn, 1'b0};
        remR     <= '0;
        quot     <= '0;
        mCnt     <= '0;
        zeroBaud <= (baudIn == '0);
      end
      if (strobes.divStep) begin
        numSh <= {numSh[NUM_W-2:0], 1'b0};
        remR  <= remNext;
        quot  <= {quot[QW-2:0], fits};
      end
      if (strobes.shift) begin
        quot <= {1'b0, quot[QW-1:1]};
        mCnt <= mCnt + MW'(1);
      end
      if (strobes.round) begin
        kR   <= kFinal;
        mR   <= mFinal[MOW-1:0];
        errR <= zeroBaud | (mFinal > M_LIMIT);
      end
    end
  end

  assign mOut   = mR;
  assign kOut   = kR;
  assign errOut = errR;

endmodule

// File: rtl/baud_divisor_calc.sv
module baud_divisor_calc
  import baud_calc_pkg::*;
#(
  parameter int CLK_W  = 25,
  parameter int BAUD_W = 24,
  parameter int FRAC_W = 2,
  parameter int K_W    = 8,
  parameter int M_MAX  = 8,
  localparam int MOW   = $clog2(M_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CLK_W-1:0]  fclkHz,
  input  logic [BAUD_W-1:0] baudTarget,
  output logic [MOW-1:0]    mExp,
  output logic [K_W-1:0]    kDiv,
  output logic              done,
  output logic              rangeErr
);

  calcStrobes_t strobes;
  logic         kBig;

  baud_calc_control #(
    .DIV_STEPS(CLK_W + FRAC_W)
  ) i_control (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .kBig   (kBig),
    .strobes(strobes),
    .done   (done)
  );

  baud_calc_datapath #(
    .CLK_W (CLK_W),
    .BAUD_W(BAUD_W),
    .FRAC_W(FRAC_W),
    .K_W   (K_W),
    .M_MAX (M_MAX)
  ) i_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .fclkIn (fclkHz),
    .baudIn (baudTarget),
    .kBig   (kBig),
    .mOut   (mExp),
    .kOut   (kDiv),
    .errOut (rangeErr)
  );

endmodule

// File: rtl/baud_divisor_calc_checker.sv
module baud_divisor_calc_checker #(
  parameter int K_W   = 8,
  parameter int M_MAX = 8,
  parameter int MOW   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [MOW-1:0] mExp,
  input logic [K_W-1:0] kDiv,
  input logic           done,
  input logic           rangeErr
);

  localparam logic [MOW-1:0] M_LIMIT = MOW'(M_MAX);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(mExp) && $stable(kDiv) && $stable(rangeErr))); // R7

  AST_M_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rangeErr) |-> (mExp <= M_LIMIT)); // R5

  AST_K_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rangeErr && (mExp != '0)) |-> kDiv[K_W-1]); // R9

endmodule

bind baud_divisor_calc baud_divisor_calc_checker #(
  .K_W  (K_W),
  .M_MAX(M_MAX),
  .MOW  (MOW)
) i_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .mExp    (mExp),
  .kDiv    (kDiv),
  .done    (done),
  .rangeErr(rangeErr)
);

// File: tb/test_baud_divisor_calc.sv
module test_baud_divisor_calc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [24:0] fclkHz = '0;
  logic [23:0] baudTarget = '0;
  logic [3:0]  mExp;
  logic [7:0]  kDiv;
  logic        done;
  logic        rangeErr;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  baud_divisor_calc i_baud_divisor_calc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fclkHz    (fclkHz),
    .baudTarget(baudTarget),
    .mExp      (mExp),
    .kDiv      (kDiv),
    .done      (done),
    .rangeErr  (rangeErr)
  );

  function automatic void model(input longint f, input longint b,
                                output int em, output int ek, output bit eerr);
    longint d;
    longint two;
    longint kr;
    em = 0; ek = 0; eerr = 1'b0;
    if (b == 0) begin
      eerr = 1'b1;
      return;
    end
    d = 2 * b;
    while (f >= (d << 8)) begin
      d = d << 1;
      em++;
    end
    two = (2 * f) / d;
    kr  = (two + 1) / 2;
    if (kr == 256) begin
      kr = 128;
      em++;
    end
    ek   = int'(kr);
    eerr = (em > 8);
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic waitDone(output bit seen);
    int waits = 0;
    seen = 1'b0;
    while (!done && waits < 200) begin
      @(negedge clk);
      waits++;
    end
    seen = done;
  endtask

  task automatic applyVec(input logic [24:0] f, input logic [23:0] b, input string tag);
    int em, ek;
    bit eerr, seen;
    model(longint'(f), longint'(b), em, ek, eerr);
    @(negedge clk);
    fclkHz = f; baudTarget = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check(seen, tag, $sformatf("f=%0d b=%0d no done, expected done=1", f, b));
    if (seen) begin
      check(rangeErr == eerr, tag, $sformatf("f=%0d b=%0d err=%0d expected %0d",
            f, b, rangeErr, eerr));
      if (!eerr)
        check(mExp == em && kDiv == ek, tag,
              $sformatf("f=%0d b=%0d m=%0d k=%0d expected m=%0d k=%0d",
                        f, b, mExp, kDiv, em, ek));
      @(negedge clk);
      check(!done, "R7", $sformatf("done=%0d one cycle after strobe, expected 0", done));
    end
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !finished) begin
        finished = 1;
        vectors++;
        misses++;
        $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    logic [24:0] fList [5];
    bit seen;
    int em, ek;
    bit eerr;
    int doneCount;
    logic [3:0] mHeld;
    logic [7:0] kHeld;
    logic errHeld;

    fList[0] = 25'd20000000; fList[1] = 25'd16000000; fList[2] = 25'd10000000;
    fList[3] = 25'h1FFFFFF;  fList[4] = 25'd1843200;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0 && rangeErr == 0 && mExp == 0 && kDiv == 0, "R1",
          $sformatf("reset outputs done=%0d err=%0d m=%0d k=%0d expected 0 0 0 0",
                    done, rangeErr, mExp, kDiv));
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 0 && rangeErr == 0 && mExp == 0 && kDiv == 0, "R1",
          $sformatf("idle outputs done=%0d err=%0d m=%0d k=%0d expected 0 0 0 0",
                    done, rangeErr, mExp, kDiv));

    // R2: anchor points
    applyVec(25'd20000000, 24'd153600, "R2");
    check(mExp == 0 && kDiv == 8'h41, "R2",
          $sformatf("153600 bps m=%0d k=%0d expected m=0 k=65", mExp, kDiv));
    applyVec(25'd20000000, 24'd300, "R2");
    check(mExp == 8 && kDiv == 8'h82, "R2",
          $sformatf("300 bps m=%0d k=%0d expected m=8 k=130", mExp, kDiv));

    // R3: rounding boundaries; R4: fix-up to 128
    applyVec(25'd508, 24'd1, "R3");
    applyVec(25'd509, 24'd1, "R3");
    check(mExp == 0 && kDiv == 255, "R3",
          $sformatf("254.5 m=%0d k=%0d expected m=0 k=255", mExp, kDiv));
    applyVec(25'd510, 24'd1, "R3");
    applyVec(25'd511, 24'd1, "R4");
    check(mExp == 1 && kDiv == 128 && !rangeErr, "R4",
          $sformatf("255.5 m=%0d k=%0d expected m=1 k=128", mExp, kDiv));
    applyVec(25'd512, 24'd1, "R2");
    applyVec(25'd1533, 24'd3, "R4");

    // R5: exponent limit around m=8/9
    applyVec(25'd130814, 24'd1, "R5");
    applyVec(25'd130944, 24'd1, "R5");
    check(rangeErr == 1, "R5",
          $sformatf("fix-up past limit err=%0d expected 1", rangeErr));
    applyVec(25'd131071, 24'd1, "R5");
    applyVec(25'h1FFFFFF, 24'd1, "R5");

    // R6: zero baud
    applyVec(25'd20000000, 24'd0, "R6");
    check(rangeErr == 1, "R6", $sformatf("zero baud err=%0d expected 1", rangeErr));

    // R8: restarts while busy are ignored
    model(64'd20000000, 64'd9600, em, ek, eerr);
    @(negedge clk);
    fclkHz = 25'd20000000; baudTarget = 24'd9600; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    fclkHz = 25'd1000; baudTarget = 24'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check(seen && mExp == em && kDiv == ek && !rangeErr, "R8",
          $sformatf("busy restart m=%0d k=%0d expected m=%0d k=%0d", mExp, kDiv, em, ek));
    doneCount = 0;
    repeat (80) begin
      @(negedge clk);
      if (done) doneCount++;
    end
    check(doneCount == 0, "R8", $sformatf("extra done count=%0d expected 0", doneCount));

    // R7: outputs hold while idle with changing inputs
    mHeld = mExp; kHeld = kDiv; errHeld = rangeErr;
    fclkHz = 25'd12345; baudTarget = 24'd0;
    repeat (10) @(negedge clk);
    check(mExp == mHeld && kDiv == kHeld && rangeErr == errHeld, "R7",
          $sformatf("held m=%0d k=%0d err=%0d expected m=%0d k=%0d err=%0d",
                    mExp, kDiv, rangeErr, mHeld, kHeld, errHeld));

    // R2/R3/R9: geometric sweep of baud for several clocks
    for (int fi = 0; fi < 5; fi++) begin
      longint b = 1;
      while (b < 64'd16777216) begin
        applyVec(fList[fi], 24'(b), "R9");
        b = b + (b >> 3) + 1;
      end
    end

    // R3/R4/R6: exhaustive baud range with a small clock
    for (int bi = 0; bi < 512; bi++) begin
      applyVec(25'd100000, 24'(bi), "R3");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule